// File: doc/BRIEF.md
# Packed-Word Colour Palette Lookup

This block turns pixel indices into 16-bit colours through a 256-entry palette. Storage is 128 words of 32 bits, and each word holds two adjacent palette entries. A simple synchronous bus port writes and reads whole words. The pixel port takes an index of 1, 2, 4 or 8 bits, chosen by a bits-per-pixel code, and returns the colour one cycle later. Both the TFT and the STN colour paths use the same lookup.

In the 16-bit mode, the pixel value does not use the palette. It appears unchanged at the colour output, with the same one-cycle delay as a lookup. Downstream logic therefore sees one fixed latency in every mode.

Top module: `palette_lut`

## Requirements
- R1: A bus cycle with `bus_en`=1 and `bus_we`=1 stores `bus_wdata` in the palette word at `bus_addr`. The storage has 128 words of 32 bits.
- R2: A bus cycle with `bus_en`=1 and `bus_we`=0 puts the word at `bus_addr` on `bus_rdata` one cycle later. `bus_rdata` keeps its value in every other cycle.
- R3: Palette entry 2k is held in bits 15:0 of word k, and entry 2k+1 in bits 31:16. Index bit 0 selects the half-word, and index bits 7:1 select the word.
- R4: The mode code selects the width of the index, which is always taken from the low bits of `pix_data`. Code 0 uses bit 0, code 1 uses bits 1:0, code 2 uses bits 3:0 and code 3 uses bits 7:0. The index is zero-extended to 8 bits, and the other bits of `pix_data` are ignored.
- R5: Mode codes 4 to 7 select the 16 bpp bypass. In these modes `color_out` equals the `pix_data` that was sampled, and the palette is not read.
- R6: `color_valid` is high in the cycle after a cycle with `pix_valid` high, and low otherwise.
- R7: `color_out` is zero whenever `color_valid` is low.
- R8: A bus write and a pixel lookup may address the same word in the same cycle. In that case the write takes effect, and the lookup returns the word's old contents.
- R9: While reset is held, `color_valid`, `color_out` and `bus_rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Palette word address |
| bus_wdata | input | 32 | Write word (two entries) |
| bus_rdata | output | 32 | Read word, one cycle after the request |
| pix_valid | input | 1 | Pixel present this cycle |
| bpp_mode | input | 3 | Bits-per-pixel code |
| pix_data | input | 16 | Index in the low bits, or direct colour in 16 bpp |
| color_valid | output | 1 | Colour output valid |
| color_out | output | 16 | Looked-up or bypassed colour |

## Verification
The bench fills the palette with odd and even entries that differ, and then reads neighbouring indices. A design that inverted the half-word select, or that used bit 0 as part of the word address, would return the partner entry or a colour from another word. In each narrow mode the bench sets the upper `pix_data` bits to ones. A design that masked the index wrongly would then look up high entries instead of low ones. In the 16 bpp mode the bench compares the output with the raw pixel value, in both back-to-back and gapped streams. It also drives a write and a lookup to the same word in one cycle. A design that bypassed the write data to the lookup would show the new colour where the old one is expected.

// File: rtl/palette_lut.sv
module palette_lut #(
  parameter int ENTRY_W = 16,
  parameter int ENTRIES = 256,
  parameter int MODE_W  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_en,
  input  logic                  bus_we,
  input  logic [$clog2(ENTRIES/2)-1:0] bus_addr,
  input  logic [2*ENTRY_W-1:0]  bus_wdata,
  output logic [2*ENTRY_W-1:0]  bus_rdata,
  input  logic                  pix_valid,
  input  logic [MODE_W-1:0]     bpp_mode,
  input  logic [ENTRY_W-1:0]    pix_data,
  output logic                  color_valid,
  output logic [ENTRY_W-1:0]    color_out
);
  localparam int WORDS  = ENTRIES / 2;
  localparam int ADDR_W = $clog2(WORDS);
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int WORD_W = 2 * ENTRY_W;

  logic [WORD_W-1:0]  mem [WORDS];
  logic [IDX_W-1:0]   idx;
  logic               bypass;
  logic [WORD_W-1:0]  pix_word_q;
  logic               hi_q, byp_q, valid_q;
  logic [ENTRY_W-1:0] byp_data_q;

  always_comb begin
    idx    = '0;
    bypass = 1'b0;
    case (bpp_mode)
      MODE_W'(0): idx = IDX_W'(pix_data[0]);
      MODE_W'(1): idx = IDX_W'(pix_data[1:0]);
      MODE_W'(2): idx = IDX_W'(pix_data[3:0]);
      MODE_W'(3): idx = pix_data[IDX_W-1:0];
      default:    bypass = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (bus_en && bus_we) mem[bus_addr] <= bus_wdata;
    if (pix_valid && !bypass) pix_word_q <= mem[idx[IDX_W-1:1]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_en && !bus_we) bus_rdata <= mem[bus_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q    <= 1'b0;
      hi_q       <= 1'b0;
      byp_q      <= 1'b0;
      byp_data_q <= '0;
    end else begin
      valid_q <= pix_valid;
      if (pix_valid) begin
        hi_q       <= idx[0];
        byp_q      <= bypass;
        byp_data_q <= pix_data;
      end
    end
  end

  assign color_valid = valid_q;
  assign color_out   = !valid_q ? '0 :
                       byp_q    ? byp_data_q :
                       hi_q     ? pix_word_q[WORD_W-1:ENTRY_W] :
                                  pix_word_q[ENTRY_W-1:0];
endmodule

// File: rtl/palette_lut_chk.sv
module palette_lut_chk #(
  parameter int ENTRY_W = 16,
  parameter int ENTRIES = 256,
  parameter int MODE_W  = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_en,
  input logic                  bus_we,
  input logic [$clog2(ENTRIES/2)-1:0] bus_addr,
  input logic [2*ENTRY_W-1:0]  bus_wdata,
  input logic [2*ENTRY_W-1:0]  bus_rdata,
  input logic                  pix_valid,
  input logic [MODE_W-1:0]     bpp_mode,
  input logic [ENTRY_W-1:0]    pix_data,
  input logic                  color_valid,
  input logic [ENTRY_W-1:0]    color_out
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> color_valid == $past(pix_valid)); // R6
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !color_valid |-> color_out == '0); // R7
  AST_BYPASS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(pix_valid) && $past(bpp_mode) >= MODE_W'(4))
      |-> color_out == $past(pix_data)); // R5
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(bus_en && !bus_we)) |-> $stable(bus_rdata)); // R2
  AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && $past(bus_en && bus_we, 2) && $past(bus_en && !bus_we)
      && $past(bus_addr) == $past(bus_addr, 2))
      |-> bus_rdata == $past(bus_wdata, 2)); // R1
endmodule

bind palette_lut palette_lut_chk #(.ENTRY_W(ENTRY_W), .ENTRIES(ENTRIES), .MODE_W(MODE_W)) u_chk (.*);

// File: tb/tb_palette_lut.sv
module tb_palette_lut;
  logic        clk = 0, rst_n = 0;
  logic        bus_en = 0, bus_we = 0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pix_valid = 0;
  logic [2:0]  bpp_mode = '0;
  logic [15:0] pix_data = '0;
  logic        color_valid;
  logic [15:0] color_out;

  int errors = 0, checks = 0;
  logic [31:0] model [128];
  logic [15:0] expq [$];
  bit done = 0;

  always #5 clk = ~clk;

  palette_lut dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expect_color(input logic [2:0] m, input logic [15:0] d);
    logic [7:0] i;
    case (m)
      3'd0: i = {7'b0, d[0]};
      3'd1: i = {6'b0, d[1:0]};
      3'd2: i = {4'b0, d[3:0]};
      3'd3: i = d[7:0];
      default: return d;
    endcase
    return i[0] ? model[i[7:1]][31:16] : model[i[7:1]][15:0];
  endfunction

  task automatic bus_write(input logic [6:0] a, input logic [31:0] d);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    model[a] = d;
    bus_en = 0; bus_we = 0;
  endtask

  task automatic bus_read_check(input logic [6:0] a, input string req);
    bus_en = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_en = 0;
    chk(bus_rdata == model[a], req, bus_rdata, model[a]);
  endtask

  task automatic drive_pix(input logic [2:0] m, input logic [15:0] d);
    pix_valid = 1; bpp_mode = m; pix_data = d;
    expq.push_back(expect_color(m, d));
    @(negedge clk);
    pix_valid = 0;
  endtask

  task automatic stream_pix(input logic [2:0] m, input logic [15:0] d);
    pix_valid = 1; bpp_mode = m; pix_data = d;
    expq.push_back(expect_color(m, d));
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (color_valid) begin
        if (expq.size() == 0) chk(0, "R6 unexpected valid", {16'b0, color_out}, 0);
        else begin
          logic [15:0] e;
          e = expq.pop_front();
          chk(color_out == e, "R3/R4/R5 colour", {16'b0, color_out}, {16'b0, e});
        end
      end else if (color_out != 0) chk(0, "R7 idle output", {16'b0, color_out}, 0);
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) model[i] = '0;
    #23;
    chk(color_valid == 0, "R9 valid in reset", {31'b0, color_valid}, 0);
    chk(color_out == 0, "R9 colour in reset", {16'b0, color_out}, 0);
    chk(bus_rdata == 0, "R9 rdata in reset", bus_rdata, 0);
    @(negedge clk); rst_n = 1; @(negedge clk);

    for (int i = 0; i < 128; i++)
      bus_write(7'(i), {8'hB0 | 8'(i >> 4), 8'(i * 2 + 1), 8'hA0 | 8'(i >> 4), 8'(i * 2)});
    bus_read_check(7'd0, "R1/R2 word 0");
    bus_read_check(7'd127, "R1/R2 word 127");
    bus_read_check(7'd42, "R1/R2 word 42");
    bus_write(7'd5, 32'hDEAD_BEEF);
    @(negedge clk);
    chk(bus_rdata == model[42], "R2 rdata hold", bus_rdata, model[42]);
    bus_read_check(7'd5, "R1 rewrite");

    // R3 neighbouring entries in 8 bpp
    drive_pix(3'd3, 16'h0000);
    drive_pix(3'd3, 16'h0001);
    drive_pix(3'd3, 16'h00FE);
    drive_pix(3'd3, 16'h00FF);
    drive_pix(3'd3, 16'hFF0B);
    // R4 narrow modes with upper bits set
    drive_pix(3'd0, 16'hFFFE);
    drive_pix(3'd0, 16'hFFFF);
    drive_pix(3'd1, 16'hFFFE);
    drive_pix(3'd2, 16'hFFF7);
    drive_pix(3'd2, 16'hFFFA);
    // R6 back-to-back stream across modes
    for (int i = 0; i < 20; i++) stream_pix(3'(i % 5), 16'(i * 16'h1357));
    pix_valid = 0;
    @(negedge clk);
    // R5 bypass codes 4..7 with gaps
    for (int m = 4; m < 8; m++) begin
      drive_pix(3'(m), 16'(16'hC0DE ^ (m << 8)));
      @(negedge clk);
    end
    // R8 collision: same word written and looked up in one cycle
    bus_en = 1; bus_we = 1; bus_addr = 7'd9; bus_wdata = 32'h1234_5678;
    pix_valid = 1; bpp_mode = 3'd3; pix_data = 16'h0013;
    expq.push_back(expect_color(3'd3, 16'h0013));
    @(negedge clk);
    model[9] = 32'h1234_5678;
    bus_en = 0; bus_we = 0; pix_valid = 0;
    drive_pix(3'd3, 16'h0013);
    drive_pix(3'd3, 16'h0012);
    @(negedge clk); @(negedge clk);
    chk(expq.size() == 0, "R6 missing outputs", 32'(expq.size()), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule